// File: doc/BRIEF.md
# Wait-for-Event Sleep Controller

This block holds a core's event flag and decides what a wait-for-event request does. If an event has already been latched, the request uses it up and the core carries on. If no event is waiting, the core goes to sleep with its halt cause recorded. A send-event strobe or any pending-interrupt line latches a new event. While the core sleeps on a wait-for-event, any of these sources, or a pulse from the periodic event stream, wakes it. A wake clears the sleep state and sets the event flag in the same clock edge.

The block also tracks a wait-for-interrupt sleep, so that the halt-cause code covers both kinds of sleep. Only an interrupt event ends a wait-for-interrupt sleep. An event-stream pulse never changes a halt cause other than a wait-for-event sleep, but every such pulse is still reported as a wake attempt. Instruction decode, the interrupt controller and the generation of the event stream live outside this block. All outputs come from registers.

Top module: `wfe_sleep_ctrl`

## Requirements
- R1: A WFE request that arrives while `evt_reg` is 1 and the core is not halted clears `evt_reg`, pulses `wfe_done` for one cycle and leaves `halt_reason` at 00.
- R2: A WFE request that arrives with `evt_reg` at 0 and no event source active drives `halt_reason` to 01 (WFE) and `halted` to 1.
- R3: `sev` or any bit of `irq_evt` sets `evt_reg` at the next edge, unless a WFE request consumes it in that same cycle.
- R4: An `evs_pulse` while `halt_reason` is 01 sets `halt_reason` to 00 and `evt_reg` to 1 at the same edge, and pulses `wfe_done`.
- R5: Every `evs_pulse` gives a one-cycle `wake_try` pulse at the next edge. When `halt_reason` is not 01, the pulse leaves `halt_reason` and `evt_reg` unchanged.
- R6: `sev` or an `irq_evt` bit during a WFE halt also releases the core. `halted` falls at the next edge and `evt_reg` becomes 1.
- R7: When a WFE request arrives in the same cycle as `sev`, `irq_evt` or `evs_pulse`, the wake is applied first. The request consumes it: no halt, `evt_reg` 0, and `wfe_done` pulses.
- R8: A WFI request while not halted (and with no WFE request and no `irq_evt` bit) sets `halt_reason` to 10 (WFI). Only an `irq_evt` bit releases it. `sev` during a WFI halt sets `evt_reg` but keeps the halt. The code 11 is reserved and never produced.
- R9: WFE and WFI requests that arrive while halted are ignored: `halt_reason` holds and `wfe_done` stays 0.
- R10: While `rst` is high and after it falls, `evt_reg`, `halted`, `wfe_done` and `wake_try` are 0 and `halt_reason` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfe_req | input | 1 | Wait-for-event request strobe |
| wfi_req | input | 1 | Wait-for-interrupt request strobe |
| sev | input | 1 | Send-event strobe |
| irq_evt | input | IRQ_W | Pending-interrupt event strobes, one per source |
| evs_pulse | input | 1 | Event-stream or timer wake pulse |
| halted | output | 1 | Core is sleeping |
| halt_reason | output | 2 | 00 none, 01 WFE, 10 WFI, 11 reserved |
| wfe_done | output | 1 | WFE request retired (consumed or woken) |
| evt_reg | output | 1 | Event flag |
| wake_try | output | 1 | An event-stream wake attempt was seen |

## Verification
Every output is one register stage from the inputs. A stimulus applied in the cycle before edge N therefore shows on all five outputs just after edge N, and `wfe_done` and `wake_try` drop again after edge N+1. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares all outputs against a behavioural model at the next falling edge, and it repeats this every cycle, including the cycle after a strobe, so a pulse that lasts too long is caught. Directed sequences cover the same-cycle races, and a random phase mixes all sources.

// File: rtl/wfe_pkg.sv
package wfe_pkg;
  typedef enum logic [1:0] {
    HR_NONE = 2'b00,
    HR_WFE  = 2'b01,
    HR_WFI  = 2'b10,
    HR_RSVD = 2'b11
  } halt_reason_e;
endpackage

// File: rtl/wfe_irq_merge.sv
module wfe_irq_merge #(
  parameter int IRQ_W = 4
) (
  input  logic [IRQ_W-1:0] irq_evt,
  output logic             irq_any
);
  logic [IRQ_W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < IRQ_W; g++) begin : g_or
    assign chain[g+1] = chain[g] | irq_evt[g];
  end
  assign irq_any = chain[IRQ_W];
endmodule

// File: rtl/wfe_decide.sv
module wfe_decide
  import wfe_pkg::*;
(
  input  halt_reason_e reason_q,
  input  logic         evt_q,
  input  logic         wfe_req,
  input  logic         wfi_req,
  input  logic         sev,
  input  logic         irq_any,
  input  logic         evs_pulse,
  output halt_reason_e reason_d,
  output logic         evt_set,
  output logic         evt_clr,
  output logic         done_d
);
  logic any_evt;
  assign any_evt = sev | irq_any;

  always_comb begin
    reason_d = reason_q;
    evt_set  = 1'b0;
    evt_clr  = 1'b0;
    done_d   = 1'b0;
    case (reason_q)
      HR_NONE: begin
        if (wfe_req) begin
          if (evt_q | any_evt | evs_pulse) begin
            evt_clr = 1'b1;
            done_d  = 1'b1;
          end else begin
            reason_d = HR_WFE;
          end
        end else begin
          evt_set = any_evt;
          if (wfi_req && !irq_any) reason_d = HR_WFI;
        end
      end
      HR_WFE: begin
        if (any_evt | evs_pulse) begin
          reason_d = HR_NONE;
          evt_set  = 1'b1;
          done_d   = 1'b1;
        end
      end
      HR_WFI: begin
        evt_set = any_evt;
        if (irq_any) reason_d = HR_NONE;
      end
      default: reason_d = HR_NONE;
    endcase
  end
endmodule

// File: rtl/wfe_evt_reg.sv
module wfe_evt_reg (
  input  logic clk,
  input  logic rst,
  input  logic evt_set,
  input  logic evt_clr,
  output logic evt_q
);
  always_ff @(posedge clk) begin
    if (rst)          evt_q <= 1'b0;
    else if (evt_clr) evt_q <= 1'b0;
    else if (evt_set) evt_q <= 1'b1;
  end
endmodule

// File: rtl/wfe_sleep_ctrl.sv
module wfe_sleep_ctrl
  import wfe_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wfe_req,
  input  logic             wfi_req,
  input  logic             sev,
  input  logic [IRQ_W-1:0] irq_evt,
  input  logic             evs_pulse,
  output logic             halted,
  output logic [1:0]       halt_reason,
  output logic             wfe_done,
  output logic             evt_reg,
  output logic             wake_try
);
  halt_reason_e reason_q, reason_d;
  logic irq_any, evt_set, evt_clr, done_d;
  logic halted_q, done_q, wake_q;

  wfe_irq_merge #(.IRQ_W(IRQ_W)) u_merge (
    .irq_evt (irq_evt),
    .irq_any (irq_any)
  );

  wfe_decide u_decide (
    .reason_q  (reason_q),
    .evt_q     (evt_reg),
    .wfe_req   (wfe_req),
    .wfi_req   (wfi_req),
    .sev       (sev),
    .irq_any   (irq_any),
    .evs_pulse (evs_pulse),
    .reason_d  (reason_d),
    .evt_set   (evt_set),
    .evt_clr   (evt_clr),
    .done_d    (done_d)
  );

  wfe_evt_reg u_evt (
    .clk     (clk),
    .rst     (rst),
    .evt_set (evt_set),
    .evt_clr (evt_clr),
    .evt_q   (evt_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reason_q <= HR_NONE;
      halted_q <= 1'b0;
      done_q   <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      reason_q <= reason_d;
      halted_q <= (reason_d != HR_NONE);
      done_q   <= done_d;
      wake_q   <= evs_pulse;
    end
  end

  assign halt_reason = reason_q;
  assign halted      = halted_q;
  assign wfe_done    = done_q;
  assign wake_try    = wake_q;
endmodule

// File: rtl/wfe_sleep_ctrl_chk.sv
module wfe_sleep_ctrl_chk #(
  parameter int IRQ_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wfe_req,
  input logic             wfi_req,
  input logic             sev,
  input logic [IRQ_W-1:0] irq_evt,
  input logic             evs_pulse,
  input logic             halted,
  input logic [1:0]       halt_reason,
  input logic             wfe_done,
  input logic             evt_reg,
  input logic             wake_try
);
  AST_WFE_CONSUME: assert property (@(posedge clk) disable iff (rst)
    (halt_reason == 2'b00 && wfe_req && evt_reg) |=> (!evt_reg && wfe_done && halt_reason == 2'b00)); // R1
  AST_WFE_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (halt_reason == 2'b00 && wfe_req && !evt_reg && !sev && irq_evt == '0 && !evs_pulse)
      |=> (halt_reason == 2'b01 && halted)); // R2
  AST_EVT_SET: assert property (@(posedge clk) disable iff (rst)
    ((sev || irq_evt != '0) && !(wfe_req && halt_reason == 2'b00)) |=> evt_reg); // R3
  AST_STREAM_WAKE: assert property (@(posedge clk) disable iff (rst)
    (halt_reason == 2'b01 && evs_pulse) |=> (halt_reason == 2'b00 && evt_reg && wfe_done)); // R4
  AST_WAKE_TRY: assert property (@(posedge clk) disable iff (rst)
    evs_pulse |=> wake_try); // R5
  AST_EVT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (halt_reason == 2'b01 && (sev || irq_evt != '0)) |=> (!halted && evt_reg)); // R6
  AST_RACE_CONSUME: assert property (@(posedge clk) disable iff (rst)
    (halt_reason == 2'b00 && wfe_req && (sev || irq_evt != '0 || evs_pulse))
      |=> (wfe_done && !evt_reg && halt_reason == 2'b00)); // R7
  AST_WFI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (halt_reason == 2'b10 && irq_evt == '0) |=> (halt_reason == 2'b10)); // R8
  AST_NO_RSVD: assert property (@(posedge clk) disable iff (rst)
    halt_reason != 2'b11); // R8
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (halt_reason == 2'b01 && !sev && irq_evt == '0 && !evs_pulse)
      |=> (halt_reason == 2'b01 && !wfe_done)); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (halt_reason == 2'b00 && !evt_reg && !halted && !wfe_done && !wake_try)); // R10
endmodule

bind wfe_sleep_ctrl wfe_sleep_ctrl_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wfe_req     (wfe_req),
  .wfi_req     (wfi_req),
  .sev         (sev),
  .irq_evt     (irq_evt),
  .evs_pulse   (evs_pulse),
  .halted      (halted),
  .halt_reason (halt_reason),
  .wfe_done    (wfe_done),
  .evt_reg     (evt_reg),
  .wake_try    (wake_try)
);

// File: tb/wfe_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module wfe_sleep_ctrl_tb_top;
  localparam int IRQ_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wfe_req = 1'b0, wfi_req = 1'b0, sev = 1'b0, evs_pulse = 1'b0;
  logic [IRQ_W-1:0] irq_evt = '0;
  logic halted, wfe_done, evt_reg, wake_try;
  logic [1:0] halt_reason;

  int errors = 0;
  int checks = 0;
  bit done_flag = 1'b0;
  string tag = "R10";

  // behavioural reference
  int m_reason = 0;
  bit m_evt = 0, m_halted = 0, m_done = 0, m_wake = 0;

  always #2.5 clk = ~clk;

  wfe_sleep_ctrl #(.IRQ_W(IRQ_W)) dut_i (
    .clk(clk), .rst(rst), .wfe_req(wfe_req), .wfi_req(wfi_req), .sev(sev),
    .irq_evt(irq_evt), .evs_pulse(evs_pulse), .halted(halted),
    .halt_reason(halt_reason), .wfe_done(wfe_done), .evt_reg(evt_reg),
    .wake_try(wake_try)
  );

  always @(posedge clk) begin
    int r;
    bit e, d, ia, ev;
    if (rst) begin
      m_reason <= 0; m_evt <= 0; m_halted <= 0; m_done <= 0; m_wake <= 0;
    end else begin
      r = m_reason; e = m_evt; d = 0;
      ia = (irq_evt != 0);
      ev = sev || ia;
      if (m_reason == 0) begin
        if (wfe_req) begin
          if (e || ev || evs_pulse) begin e = 0; d = 1; end
          else r = 1;
        end else begin
          if (ev) e = 1;
          if (wfi_req && !ia) r = 2;
        end
      end else if (m_reason == 1) begin
        if (ev || evs_pulse) begin r = 0; e = 1; d = 1; end
      end else begin
        if (ev) e = 1;
        if (ia) r = 0;
      end
      m_reason <= r; m_evt <= e; m_done <= d; m_wake <= evs_pulse;
      m_halted <= (r != 0);
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk({tag, " model"}, {halted, halt_reason, wfe_done, evt_reg, wake_try},
        {m_halted, m_reason[1:0], m_done, m_evt, m_wake});
  endtask

  // drive at negedge, one rising edge, compare at next negedge
  task automatic step(input bit w, input bit i, input bit s,
                      input logic [IRQ_W-1:0] q, input bit e);
    wfe_req = w; wfi_req = i; sev = s; irq_evt = q; evs_pulse = e;
    @(posedge clk);
    @(negedge clk);
    wfe_req = 0; wfi_req = 0; sev = 0; irq_evt = '0; evs_pulse = 0;
    cmp_model();
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done_flag) begin
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    tag = "R10";
    chk("R10 reset outputs", {halted, halt_reason, wfe_done, evt_reg, wake_try}, 0);
    rst = 0;
    step(0, 0, 0, 0, 0);
    chk("R10 after reset", {halted, halt_reason, evt_reg}, 0);

    tag = "R2"; step(1, 0, 0, 0, 0);
    chk("R2 halt reason WFE", halt_reason, 2'b01);
    chk("R2 halted", halted, 1);

    tag = "R9"; step(1, 0, 0, 0, 0);
    chk("R9 reason held", halt_reason, 2'b01);
    chk("R9 no retire", wfe_done, 0);
    step(0, 1, 0, 0, 0);
    chk("R9 wfi ignored", halt_reason, 2'b01);

    tag = "R4"; step(0, 0, 0, 0, 1);
    chk("R4 reason cleared", halt_reason, 2'b00);
    chk("R4 event set", evt_reg, 1);
    chk("R4 retire", wfe_done, 1);
    step(0, 0, 0, 0, 0);
    chk("R4 retire one cycle", wfe_done, 0);

    tag = "R1"; step(1, 0, 0, 0, 0);
    chk("R1 consumed", evt_reg, 0);
    chk("R1 retire", wfe_done, 1);
    chk("R1 no halt", halt_reason, 2'b00);

    tag = "R5"; step(0, 0, 0, 0, 1);
    chk("R5 wake_try", wake_try, 1);
    chk("R5 evt untouched", evt_reg, 0);
    chk("R5 reason untouched", halt_reason, 2'b00);
    step(0, 0, 0, 0, 0);
    chk("R5 wake_try one cycle", wake_try, 0);

    tag = "R3"; step(0, 0, 1, 0, 0);
    chk("R3 sev sets", evt_reg, 1);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 4'b0100, 0);
    chk("R3 irq bit sets", evt_reg, 1);
    step(1, 0, 0, 0, 0);

    tag = "R6"; step(1, 0, 0, 0, 0);
    step(0, 0, 0, 4'b1000, 0);
    chk("R6 irq release", halted, 0);
    chk("R6 evt set", evt_reg, 1);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R6 sev release", halted, 0);
    step(1, 0, 0, 0, 0);

    tag = "R7"; step(1, 0, 0, 0, 1);
    chk("R7 evs race", {halt_reason, evt_reg, wfe_done}, 3'b001);
    step(1, 0, 1, 0, 0);
    chk("R7 sev race", {halt_reason, evt_reg, wfe_done}, 3'b001);
    step(1, 0, 0, 4'b0001, 0);
    chk("R7 irq race", {halt_reason, evt_reg, wfe_done}, 3'b001);

    tag = "R8"; step(0, 1, 0, 0, 0);
    chk("R8 wfi halt", halt_reason, 2'b10);
    step(0, 0, 1, 0, 0);
    chk("R8 sev keeps wfi", {halt_reason, evt_reg}, 3'b101);
    tag = "R5"; step(0, 0, 0, 0, 1);
    chk("R5 stream leaves wfi", {halt_reason, wake_try}, 3'b101);
    tag = "R8"; step(0, 0, 0, 4'b0010, 0);
    chk("R8 irq releases wfi", {halted, halt_reason}, 3'b000);
    step(1, 0, 0, 0, 0);

    tag = "RANDOM(R1,R2,R3,R4,R6,R7,R8)";
    for (int n = 0; n < 2000; n++) begin
      step(($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 10) == 0,
           (($urandom % 12) == 0) ? IRQ_W'($urandom) : '0, ($urandom % 9) == 0);
    end

    tag = "R10"; rst = 1;
    @(posedge clk); @(negedge clk);
    cmp_model();
    chk("R10 reset again", {halted, halt_reason, wfe_done, evt_reg, wake_try}, 0);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule